// File: doc/BRIEF.md
# Multi-Channel Frame PWM Controller

This block generates up to four independent pulse-width-modulated outputs from one clock. Each channel has a single 32-bit control word, reached over a simple memory-mapped write/read bus. The word carries an enable flag, an 8-bit high-time count and a 13-bit clock divider. A channel divides the clock by its divider to form a tick. Every period is a frame of 256 ticks, and the output stays high for the first `duty` ticks of each frame.

Software programs a channel by writing its word, and can read it back at any time. A change of high time or divider on a running channel waits for the current frame to finish, so no partial period is ever produced. Writing zero to a word stops the channel and parks its output low.

Top module: `pwm_frame_ctrl`

## Requirements
- R1: Bit 31 of a control word is the enable, bits 23:16 the duty count and bits 12:0 the divider. Channel n's word sits at byte address n*16 (address bits 5:4 = n, bits 3:0 and 7:6 zero). A write to any other address changes no word, and a read of any other address returns 0.
- R2: Reading a channel address returns the last value written there, with bits 30:24 and 15:13 always reading 0.
- R3: One tick of an enabled channel lasts divider+1 clock cycles, so a divider of 0 advances the tick every cycle.
- R4: A frame is 256 ticks. The output is high while the tick index (0..255) is below the duty count. A duty of 0 keeps the output low, and 255 gives 255 high ticks per frame.
- R5: While a channel's enable bit is 0 its output is low and its tick and divider counters are held at zero. Writing all zeros disables the channel.
- R6: In the first clock cycle after the enable bit is set, the channel is at tick 0 with a cleared divider counter and uses the newly written duty and divider.
- R7: A duty or divider written to an enabled channel takes effect only from the first tick of the next frame.
- R8: A write to one channel leaves every other channel's word and output sequence unaffected.
- R9: After a synchronous active-low reset, every word reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the PWM time base |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The bench targets the frame boundary. A mid-frame update that leaked through early would show a shortened or stretched high pulse in the middle of a period. The duty extremes 0 and 255 are run, where an off-by-one compare would give a one-tick spike or a full-high frame. Divider 0 is run, where a counter that treated 0 as a divide by 2 would double the period. The bench also probes aliased and out-of-range addresses, reserved bits and re-enabling after a zero write. A design that did not restart at tick 0 would show a phase error on its first frame.

// File: rtl/pwm_pkg.sv
// Package: shared field positions and the per-channel configuration type.
// Assumes a 32-bit control word with fixed field positions.
package pwm_pkg;
    localparam int REG_W        = 32;
    localparam int EN_BIT       = 31;
    localparam int DUTY_LSB     = 16;
    localparam int DUTY_W       = 8;
    localparam int PSC_LSB      = 0;
    localparam int PSC_W        = 13;
    localparam int STRIDE_SHIFT = 4;
    localparam int MAX_CH       = 4;
    localparam int CH_BITS      = $clog2(MAX_CH);

    localparam logic [REG_W-1:0] REG_MASK =
        (REG_W'(1) << EN_BIT) |
        (((REG_W'(1) << DUTY_W) - 1) << DUTY_LSB) |
        (((REG_W'(1) << PSC_W) - 1) << PSC_LSB);

    typedef struct packed {
        logic              en;
        logic [DUTY_W-1:0] duty;
        logic [PSC_W-1:0]  psc;
    } ch_cfg_t;

    // Split a stored control word into its fields.
    function automatic ch_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        ch_cfg_t c;
        c.en   = w[EN_BIT];
        c.duty = w[DUTY_LSB +: DUTY_W];
        c.psc  = w[PSC_LSB +: PSC_W];
        return c;
    endfunction
endpackage

// File: rtl/pwm_regfile.sv
// Module: control-word storage with address decode and readback.
// Assumes words at a 16-byte stride and reserved bits stored as zero.
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output ch_cfg_t [NUM_CH-1:0]     cfg_o
);
    localparam int UPPER = STRIDE_SHIFT + CH_BITS;

    logic               hit;
    logic [CH_BITS-1:0] idx;
    logic [REG_W-1:0]   words [NUM_CH];

    // Decode the byte address into a channel index and a valid flag.
    always_comb begin
        idx = addr[STRIDE_SHIFT +: CH_BITS];
        hit = (addr[STRIDE_SHIFT-1:0] == '0) &&
              ((addr >> UPPER) == '0) &&
              (int'(idx) < NUM_CH);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_word
        // Store a masked write into this channel's word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (wr_en && hit && (int'(idx) == i))
                words[i] <= wdata & REG_MASK;
        end

        assign cfg_o[i] = word_to_cfg(words[i]);

        // A write aimed elsewhere must leave this word untouched.
        assert_other_word_kept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !(hit && (int'(idx) == i))) |=> $stable(words[i]))
            else $error("word %0d changed by a foreign write", i);
    end

    // Return the addressed word, or zero for an unmapped address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (hit && (int'(idx) == i))
                rdata = words[i];
    end
endmodule

// File: rtl/pwm_chan.sv
// Module: one PWM channel - tick divider, 256-tick frame counter, shadowed
// duty/divider applied at frame boundaries. Assumes the config inputs are
// register outputs that change only on clock edges.
module pwm_chan #(
    parameter int DUTY_W = 8,
    parameter int PSC_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [PSC_W-1:0]  psc_i,
    output logic              pwm_o
);
    localparam logic [DUTY_W-1:0] TICK_LAST = '1;

    logic              run_q;
    logic [PSC_W-1:0]  div_q, act_psc_q, eff_psc;
    logic [DUTY_W-1:0] tick_q, act_duty_q, eff_duty;
    logic              tick_end;

    // Use the live config on the first enabled cycle, the shadow afterwards.
    always_comb begin
        eff_psc  = run_q ? act_psc_q  : psc_i;
        eff_duty = run_q ? act_duty_q : duty_i;
        tick_end = (div_q == eff_psc);
    end

    // Advance the divider and tick counters; reload the shadow per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_q      <= 1'b0;
            div_q      <= '0;
            tick_q     <= '0;
            act_duty_q <= '0;
            act_psc_q  <= '0;
        end else begin
            run_q <= 1'b1;
            if (!run_q) begin
                act_duty_q <= duty_i;
                act_psc_q  <= psc_i;
            end
            if (tick_end) begin
                div_q  <= '0;
                tick_q <= tick_q + 1'b1;
                if (run_q && tick_q == TICK_LAST) begin
                    act_duty_q <= duty_i;
                    act_psc_q  <= psc_i;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign pwm_o = en_i && (tick_q < eff_duty);

    // Disabled channel parks both counters at zero.
    assert_idle_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tick_q == '0 && div_q == '0))
        else $error("counters not cleared while disabled");

    // Enabling starts a fresh frame.
    assert_start_fresh_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> (tick_q == '0 && div_q == '0))
        else $error("frame did not start at tick 0");

    // Divider counter never passes the active divide value.
    assert_div_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (div_q <= act_psc_q))
        else $error("divider counter out of range");

    // Shadow settings hold for the whole frame.
    assert_frame_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && tick_q != '0) |-> ($stable(act_duty_q) && $stable(act_psc_q)))
        else $error("settings changed inside a frame");
endmodule

// File: rtl/pwm_frame_ctrl.sv
// Module: top of the multi-channel frame PWM controller. Connects the
// word storage to NUM_CH channel engines. Assumes NUM_CH <= 4.
module pwm_frame_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    ch_cfg_t [NUM_CH-1:0] cfg;

    pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_chan #(.DUTY_W(DUTY_W), .PSC_W(PSC_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (cfg[i].en),
            .duty_i (cfg[i].duty),
            .psc_i  (cfg[i].psc),
            .pwm_o  (pwm_o[i])
        );
    end
endmodule

// File: tb/sim_pwm_frame_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_frame_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string tag = "R9";

    // Behavioural reference state per channel.
    int m_word [4];
    int m_run  [4];
    int m_div  [4];
    int m_tick [4];
    int m_ld   [4];
    int m_lp   [4];

    always #4 clk = ~clk;

    pwm_frame_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
    );

    function automatic int addr_ch(input int a);
        if ((a % 16) == 0 && (a / 16) < 4) return a / 16;
        return -1;
    endfunction

    function automatic bit model_out(input int c);
        int en, d;
        en = (m_word[c] >>> 31) & 1;
        d  = (m_word[c] >> 16) & 255;
        if (m_run[c] != 0) d = m_ld[c];
        return (en != 0) && (m_tick[c] < d);
    endfunction

    // Reference update on each rising edge, using pre-edge state.
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            int en, d, p;
            en = (m_word[c] >>> 31) & 1;
            d  = (m_word[c] >> 16) & 255;
            p  = m_word[c] & 8191;
            if (!rst_n || en == 0) begin
                m_run[c] = 0; m_div[c] = 0; m_tick[c] = 0;
            end else begin
                if (m_run[c] == 0) begin
                    m_run[c] = 1; m_ld[c] = d; m_lp[c] = p;
                end
                if (m_div[c] == m_lp[c]) begin
                    m_div[c] = 0;
                    if (m_tick[c] == 255) begin
                        m_tick[c] = 0; m_ld[c] = d; m_lp[c] = p;
                    end else begin
                        m_tick[c] = m_tick[c] + 1;
                    end
                end else begin
                    m_div[c] = m_div[c] + 1;
                end
            end
        end
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) m_word[c] = 0;
        end else if (bus_wr_en && addr_ch(int'(bus_addr)) >= 0) begin
            m_word[addr_ch(int'(bus_addr))] = int'(bus_wdata & 32'h80FF_1FFF);
        end
    end

    // Compare every output against the reference away from the edge.
    always @(negedge clk) begin
        if (chk_on) begin
            for (int c = 0; c < 4; c++) begin
                checks++;
                if (pwm_o[c] !== model_out(c)) begin
                    errors++;
                    $display("FAIL %s ch%0d pwm_o=%0b expected %0b at %0t",
                             tag, c, pwm_o[c], model_out(c), $time);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h = 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R9: reset state of every word
        for (int c = 0; c < 4; c++) rd_chk(8'(c * 16), 32'h0, "R9");

        // R1/R2: program all channels, one with reserved bits set
        tag = "R6";
        wr(8'h00, 32'h8040_0000);
        wr(8'h10, 32'hFFC8_E002);
        wr(8'h20, 32'h8000_0000);
        wr(8'h30, 32'h80FF_0001);
        rd_chk(8'h00, 32'h8040_0000, "R1");
        rd_chk(8'h10, 32'h80C8_0002, "R2");
        rd_chk(8'h30, 32'h80FF_0001, "R1");

        // R4: duty 64 / 200 / 0 / 255 across full frames
        tag = "R4";
        run(1100);

        // R7: change duty and divider mid-frame on channel 0
        tag = "R7";
        run(37);
        wr(8'h00, 32'h800A_0003);
        run(2600);

        // R1: unmapped and misaligned writes are ignored
        tag = "R1";
        wr(8'h08, 32'h8011_0000);
        wr(8'h44, 32'h8022_0000);
        wr(8'h40, 32'h8033_0000);
        rd_chk(8'h08, 32'h0, "R1");
        rd_chk(8'h40, 32'h0, "R1");
        rd_chk(8'h00, 32'h800A_0003, "R1");

        // R8: writing channel 1 leaves channel 3 word as it was
        tag = "R8";
        wr(8'h10, 32'h8020_0000);
        rd_chk(8'h30, 32'h80FF_0001, "R8");
        run(300);

        // R5: zero write disables channel 1
        tag = "R5";
        wr(8'h10, 32'h0);
        rd_chk(8'h10, 32'h0, "R5");
        run(50);

        // R6: re-enable mid-way through others' frames
        tag = "R6";
        wr(8'h10, 32'h8080_0001);
        run(600);

        // R3: larger divider on a running channel
        tag = "R3";
        wr(8'h20, 32'h8080_0004);
        run(2700);

        // R9: reset while running
        tag = "R9";
        @(negedge clk); rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) rd_chk(8'(c * 16), 32'h0, "R9");
        run(20);

        chk_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule